// File: doc/BRIEF.md
# PLL clock enable controller

This block is the control and status logic that sits between software and a clock-multiplying PLL. It holds three things behind a small register port: the multiplier code (×3, ×4 or ×5 of the main clock), the PLL power-down bit, and the fast-clock select bit. When the select bit is 1, the system clock runs from the main clock. When it is 0, the system clock runs from the PLL.

Software brings the PLL up in three steps. It writes the multiplier code. It clears the power-down bit. It then writes a 0 to the select bit, reads it back, and repeats until the bit reads 0. The controller turns down each such request until a synchronized lock indication from the PLL is present. While the PLL drives the system clock, the multiplier code is frozen. An attempt to change it is dropped and recorded in a sticky error flag. A status output reports when the PLL is the active clock at ×4, which is the setting a 48 MHz consumer needs.

Frequency synthesis itself is not part of the block. The PLL appears only as the power-down and multiplier outputs and the asynchronous lock input.

Top module: `pllc_top`

## Requirements
- R1: After reset, the power-down bit is 1, the select bit is 1 (main clock), the multiplier code is 01 (×4), the error flag is 0 and `usb_ready` is 0.
- R2: The register map is as follows:
  - Address 0 holds the multiplier code in bits [1:0]: 00 is ×3, 01 is ×4, 10 is ×5.
  - Address 1 holds power-down in bit 0 and select in bit 1.
  - Address 2 holds status: lock in bit 0, error in bit 1, usb-ready in bit 2.
  - Address 3 reads as zero.
  - `rdata` follows `addr` combinationally, and `mult_factor` presents 3, 4 or 5 for the current code.
- R3: The lock status bit reads 1 only when power-down is 0 and `pll_lock_in` has been high for SYNC_STAGES consecutive clock edges.
- R4: A write to address 1 with bit 0 = 0 and bit 1 = 0 while lock status is 0 is refused: the select bit stays 1.
- R5: The same write while lock status is 1 clears the select bit from the next edge on, and `pll_active` rises.
- R6: A write to address 1 with bit 1 = 1 sets the select bit, which returns the system clock to the main clock.
- R7: A write to address 1 with bit 0 = 1 sets power-down and forces the select bit to 1 whatever bit 1 holds. The lock status reads 0 while power-down is 1.
- R8: A write to address 0 while the select bit is 0 leaves the multiplier code unchanged and sets the error flag. The flag stays set until a write to address 2 with bit 1 = 1.
- R9: A write of the reserved code 11 to address 0 leaves the code unchanged and does not set the error flag.
- R10: `usb_ready` is 1 exactly when the select bit is 0 and the multiplier code is 01 (×4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (2) | Register address for both read and write |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Read data for `addr`, combinational |
| pll_lock_in | input | 1 | Asynchronous lock indication from the PLL |
| pll_pwrdn | output | 1 | Power-down control to the PLL |
| pll_mult_code | output | 2 | Multiplier code to the PLL |
| mult_factor | output | 3 | Multiplication factor (3, 4 or 5) |
| pll_active | output | 1 | System clock is taken from the PLL |
| usb_ready | output | 1 | PLL active at ×4 |
| mode_err | output | 1 | Sticky flag for a blocked multiplier write |

## Verification
The bench builds the block with SYNC_STAGES = 2 and DATA_W = 8. Its PLL model raises lock 12 cycles after power-down is released. That delay forces the first select-clear request to be refused and makes software poll several times before the switch is taken. The two-stage synchronizer keeps the lag between the lock input and the status bit short, so the reference model's sample queue can be compared against the output on every clock, including the cycle where power-down drops the lock status immediately.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

  typedef enum logic [1:0] {
    MULT_X3   = 2'b00,
    MULT_X4   = 2'b01,
    MULT_X5   = 2'b10,
    MULT_RSVD = 2'b11
  } mult_e;

  // register addresses
  localparam int REG_MODE = 0;
  localparam int REG_CTRL = 1;
  localparam int REG_STAT = 2;

  // bit positions
  localparam int CTRL_PD_BIT   = 0;
  localparam int CTRL_SEL_BIT  = 1;
  localparam int STAT_LOCK_BIT = 0;
  localparam int STAT_ERR_BIT  = 1;
  localparam int STAT_USB_BIT  = 2;

  function automatic logic [2:0] factor_of(mult_e m);
    case (m)
      MULT_X3: return 3'd3;
      MULT_X5: return 3'd5;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic code_ok(logic [1:0] c);
    return c != MULT_RSVD;
  endfunction

endpackage

// File: rtl/pllc_lock_sync.sv
module pllc_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= async_in;
      end
      assign sync_out = q;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
      end
      assign sync_out = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pllc_clk_sel.sv
module pllc_clk_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic wr_pd,
  input  logic wr_sel,
  input  logic lock_ok,
  output logic pwr_down,
  output logic fast_sel,
  output logic evt_sel_refused,
  output logic evt_sel_to_pll
);
  logic clear_req;

  assign clear_req       = ctrl_wr & ~wr_pd & ~wr_sel;
  assign evt_sel_refused = clear_req & ~lock_ok;
  assign evt_sel_to_pll  = clear_req & lock_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_down <= 1'b1;
      fast_sel <= 1'b1;
    end else if (ctrl_wr) begin
      pwr_down <= wr_pd;
      if (wr_pd || wr_sel) fast_sel <= 1'b1;
      else                 fast_sel <= ~lock_ok;
    end
  end
endmodule

// File: rtl/pllc_mode_reg.sv
module pllc_mode_reg
  import pllc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] wr_code,
  input  logic       pll_selected,
  input  logic       err_clr,
  output mult_e      mode,
  output logic       err,
  output logic       evt_blocked,
  output logic       evt_reserved
);
  assign evt_blocked  = mode_wr & pll_selected;
  assign evt_reserved = mode_wr & ~pll_selected & ~code_ok(wr_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MULT_X4;
      err  <= 1'b0;
    end else begin
      if (mode_wr) begin
        if (pll_selected)          err  <= 1'b1;
        else if (code_ok(wr_code)) mode <= mult_e'(wr_code);
      end else if (err_clr) begin
        err <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pllc_top.sv
module pllc_top
  import pllc_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pll_lock_in,
  output logic              pll_pwrdn,
  output logic [1:0]        pll_mult_code,
  output logic [2:0]        mult_factor,
  output logic              pll_active,
  output logic              usb_ready,
  output logic              mode_err
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(REG_MODE);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);

  logic  lock_sync, lock_ok;
  logic  pwr_down, fast_sel;
  logic  mode_wr, ctrl_wr, stat_wr;
  logic  evt_sel_refused, evt_sel_to_pll, evt_blocked, evt_reserved;
  mult_e mode;
  logic  err;
  logic  unused_wdata_bits;

  assign unused_wdata_bits = ^wdata[DATA_W-1:2];

  assign mode_wr = wr_en && (addr == A_MODE);
  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign stat_wr = wr_en && (addr == A_STAT);

  pllc_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pll_lock_in), .sync_out(lock_sync)
  );

  assign lock_ok = lock_sync & ~pwr_down;

  pllc_clk_sel u_sel (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .wr_pd(wdata[CTRL_PD_BIT]), .wr_sel(wdata[CTRL_SEL_BIT]),
    .lock_ok(lock_ok), .pwr_down(pwr_down), .fast_sel(fast_sel),
    .evt_sel_refused(evt_sel_refused), .evt_sel_to_pll(evt_sel_to_pll)
  );

  pllc_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .wr_code(wdata[1:0]),
    .pll_selected(~fast_sel), .err_clr(stat_wr && wdata[STAT_ERR_BIT]),
    .mode(mode), .err(err), .evt_blocked(evt_blocked), .evt_reserved(evt_reserved)
  );

  assign pll_pwrdn     = pwr_down;
  assign pll_mult_code = mode;
  assign mult_factor   = factor_of(mode);
  assign pll_active    = ~fast_sel;
  assign usb_ready     = ~fast_sel && (mode == MULT_X4);
  assign mode_err      = err;

  always_comb begin
    rdata = '0;
    if (addr == A_MODE) begin
      rdata[1:0] = mode;
    end else if (addr == A_CTRL) begin
      rdata[CTRL_PD_BIT]  = pwr_down;
      rdata[CTRL_SEL_BIT] = fast_sel;
    end else if (addr == A_STAT) begin
      rdata[STAT_LOCK_BIT] = lock_ok;
      rdata[STAT_ERR_BIT]  = err;
      rdata[STAT_USB_BIT]  = usb_ready;
    end
  end
endmodule

// File: rtl/pllc_checker.sv
module pllc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_down,
  input logic       fast_sel,
  input logic       lock_ok,
  input logic [1:0] mode,
  input logic       err,
  input logic       mode_wr,
  input logic [1:0] wr_code,
  input logic       evt_sel_refused
);
  assert_pd_forces_main_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> fast_sel);

  assert_sel_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fast_sel) |-> $past(lock_ok));

  assert_refused_keeps_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sel_refused |=> fast_sel);

  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_sel |=> $stable(mode));

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(mode_wr && !fast_sel));

  assert_rsvd_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && wr_code == 2'b11) |=> ($stable(mode) && !$rose(err)) || $past(!fast_sel));
endmodule

bind pllc_top pllc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .fast_sel(fast_sel),
  .lock_ok(lock_ok), .mode(mode), .err(err), .mode_wr(mode_wr),
  .wr_code(wdata[1:0]), .evt_sel_refused(evt_sel_refused)
);

// File: tb/sim_pllc_top.sv
module sim_pllc_top;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 2;
  localparam int LOCK_DELAY = 12;

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, pll_lock_in = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pll_pwrdn, pll_active, usb_ready, mode_err;
  logic [1:0] pll_mult_code;
  logic [2:0] mult_factor;

  pllc_top #(.ADDR_W(2), .DATA_W(8), .SYNC_STAGES(STAGES)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pll_lock_in(pll_lock_in), .pll_pwrdn(pll_pwrdn),
    .pll_mult_code(pll_mult_code), .mult_factor(mult_factor),
    .pll_active(pll_active), .usb_ready(usb_ready), .mode_err(mode_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_pd, m_sel, m_mode, m_err;
  int hist[$];

  function automatic int m_lock();
    int s;
    s = (hist.size() == STAGES) ? hist[0] : 0;
    return (s != 0 && m_pd == 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int ok;
    if (!rst_n) begin
      m_pd = 1; m_sel = 1; m_mode = 1; m_err = 0;
      hist.delete();
    end else begin
      ok = m_lock();
      if (wr_en) begin
        case (addr)
          2'd0: if (m_sel == 0) m_err = 1;
                else if (wdata[1:0] != 2'b11) m_mode = int'(wdata[1:0]);
          2'd1: begin
            m_pd = int'(wdata[0]);
            if (wdata[0] || wdata[1]) m_sel = 1;
            else m_sel = ok ? 0 : 1;
          end
          2'd2: if (wdata[1]) m_err = 0;
          default: ;
        endcase
      end
      hist.push_back(int'(pll_lock_in));
      if (hist.size() > STAGES) void'(hist.pop_front());
    end
  end

  bit run_cmp = 0;
  always @(negedge clk) begin
    int usb, exp_rd;
    if (rst_n && run_cmp) begin
      usb = (m_sel == 0 && m_mode == 1) ? 1 : 0;
      case (addr)
        2'd0: exp_rd = m_mode;
        2'd1: exp_rd = (m_sel << 1) | m_pd;
        2'd2: exp_rd = (usb << 2) | (m_err << 1) | m_lock();
        default: exp_rd = 0;
      endcase
      chk("R2 rdata", rdata, exp_rd);
      chk("R7 pll_pwrdn", pll_pwrdn, m_pd);
      chk("R8 pll_mult_code", pll_mult_code, m_mode);
      chk("R2 mult_factor", mult_factor, 3 + m_mode);
      chk("R5 pll_active", pll_active, m_sel == 0);
      chk("R10 usb_ready", usb_ready, usb);
      chk("R8 mode_err", mode_err, m_err);
    end
  end

  // PLL model: lock rises LOCK_DELAY cycles after power-down is released
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      if (pll_pwrdn) begin cnt = 0; pll_lock_in = 1'b0; end
      else if (cnt < LOCK_DELAY) cnt++;
      else pll_lock_in = 1'b1;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(posedge clk); #1;
    wr_en = 1'b0; addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    bit done;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    run_cmp = 1;

    // R1 reset state
    rd(2'd0, v); chk("R1 mode after reset", v, 8'h01);
    rd(2'd1, v); chk("R1 ctrl after reset", v, 8'h03);
    rd(2'd2, v); chk("R1 status after reset", v, 8'h00);
    chk("R1 pll_pwrdn", pll_pwrdn, 1);
    chk("R1 mult_factor", mult_factor, 4);

    // R2 mode write on main clock
    wr(2'd0, 8'h02);
    rd(2'd0, v); chk("R2 mode x5", v, 8'h02);
    chk("R2 factor x5", mult_factor, 5);
    rd(2'd3, v); chk("R2 addr3 zero", v, 8'h00);

    // R9 reserved code
    wr(2'd0, 8'h03);
    rd(2'd0, v); chk("R9 reserved ignored", v, 8'h02);
    rd(2'd2, v); chk("R9 no error", v[1], 0);

    // R4 refused before lock
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R4 select refused", v, 8'h02);
    rd(2'd2, v); chk("R3 no lock yet", v[0], 0);

    // R5 poll until accepted
    done = 0;
    for (int i = 0; i < 40 && !done; i++) begin
      wr(2'd1, 8'h00);
      rd(2'd1, v);
      if (v[1] == 1'b0) done = 1;
    end
    chk("R5 select accepted after lock", done, 1);
    rd(2'd2, v); chk("R3 lock status", v[0], 1);
    chk("R5 pll_active", pll_active, 1);
    chk("R10 usb off at x5", usb_ready, 0);

    // R8 blocked mode write
    wr(2'd0, 8'h01);
    rd(2'd0, v); chk("R8 mode frozen", v, 8'h02);
    chk("R8 error set", mode_err, 1);

    // R6 back to main
    wr(2'd1, 8'h02);
    rd(2'd1, v); chk("R6 select set", v, 8'h02);
    chk("R6 pll_active off", pll_active, 0);

    // R8 sticky then clear
    wr(2'd0, 8'h01);
    rd(2'd0, v); chk("R8 mode x4 accepted", v, 8'h01);
    chk("R8 error sticky", mode_err, 1);
    wr(2'd2, 8'h02);
    rd(2'd2, v); chk("R8 error cleared", v[1], 0);

    // R10 usb ready
    wr(2'd1, 8'h00);
    rd(2'd2, v); chk("R10 usb status bit", v[2], 1);
    chk("R10 usb_ready", usb_ready, 1);

    // R7 power-down forces main clock
    wr(2'd1, 8'h01);
    rd(2'd1, v); chk("R7 ctrl forced", v, 8'h03);
    rd(2'd2, v); chk("R7 lock dropped", v[0], 0);
    chk("R7 pll_active off", pll_active, 0);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule